// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock Stretching

This block is the target side of an I2C bus. It watches the synchronised clock and data lines for START and STOP, compares the first byte after a START against a programmable 7-bit own address, and acknowledges it on a match. It then moves one byte at a time between the bus and a small host register file. After each byte it holds the clock line low, so the master waits until the host has dealt with the data.

The host sees four registers and one interrupt line. It reads status at each interrupt. It then writes control to pick the transfer direction from the master's read/write bit. Last, it either writes the data register (transmit) or reads it (receive). That data register access is the only back-pressure handshake: the bus stays stretched until the access arrives in the direction selected in control. An access in the other direction leaves the bus held. Data flows on the bus side without any queue, so the host always has exactly one byte in flight.

Register selects are 0 for own address (bits 6:0), 1 for control, 2 for status and 3 for data. Control bit 0 enables the block, bit 1 selects transmit, and bit 2 turns off the acknowledge in receive. Status bit 0 is the pending interrupt, bit 1 the addressed flag, bit 2 the master's read/write bit (1 = master reads), and bit 3 the received acknowledge (1 = master sent NACK).

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset scl_oe, sda_oe and irq are 0 and status reads 0x00.
- R2: On an address byte whose upper seven bits equal the own address, the slave pulls SDA low in the ninth clock. After that clock falls it sets status bits 0 and 1 and copies the address byte's bit 0 into status bit 2.
- R3: On an address mismatch the slave does not pull SDA, raises no interrupt and does not stretch SCL.
- R4: A control register write clears status bit 1, and interrupts raised by data bytes leave status bit 1 at 0.
- R5: After every acknowledged byte SCL is held low (scl_oe = 1) until the data register is read with control bit 1 = 0 or written with control bit 1 = 1. An access in the other direction does not release it.
- R6: In receive the slave shifts bytes in MSB first, acknowledges each with SDA low while control bit 2 is 0, and shows the byte in the data register.
- R7: With control bit 2 = 1 the slave leaves SDA released in the acknowledge clock of a received byte (NACK), yet still stores the byte.
- R8: In transmit the written byte is driven MSB first, and the master's acknowledge bit is stored in status bit 3 (0 = ACK).
- R9: After a NACK from the master in transmit, status bit 3 is 1 and an interrupt is raised. SCL is not stretched, SDA stays released, and further clocks are ignored until START or STOP.
- R10: A START or repeated START at any point abandons the current byte and the slave accepts a new address byte.
- R11: Writing status with bit 0 = 1 clears the pending interrupt and the irq output.
- R12: With control bit 0 = 0 the slave drives neither line and ignores all bus traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed bus clock line |
| sda_i | input | 1 | Sensed bus data line |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_sel | input | 2 | Register select: 0 address, 1 control, 2 status, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data register) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Pending interrupt |

## Verification
Two host-side actions can land in the same cycle as a bus-side event: a control write that clears the addressed flag, and the end of the acknowledge clock that sets it. A status clear can also meet a new byte interrupt. The bench drives an open-drain master model and a host model together. A scoreboard queue holds the bytes that each side expects to see. Status is read back after every interrupt, and the bench checks that a cleared flag stays cleared once data bytes follow. It also checks that a wrong-direction access leaves the line stretched, and that a repeated START halfway through a byte is accepted cleanly as a new address.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
  localparam logic [1:0] SEL_OWN  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  localparam int CTL_EN    = 0;
  localparam int CTL_TX    = 1;
  localparam int CTL_NOACK = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_HOLD, S_RX, S_RACK, S_TX, S_TACK
  } eng_state_t;
  localparam eng_state_t S_WAIT = S_IDLE;
endpackage

// File: rtl/i2cs_sync.sv
`timescale 1ns/1ps
module i2cs_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
      last <= '1;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      last <= stg[STAGES-1];
    end
  end

  assign q    = stg[STAGES-1];
  assign rise = q & ~last;
  assign fall = ~q & last;
endmodule

// File: rtl/i2cs_engine.sv
`timescale 1ns/1ps
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tx_sel,
  input  logic              ack_off,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              ev_addr,
  output logic              ev_rx,
  output logic              ev_tx,
  output logic              rw_bit,
  output logic              nack,
  output logic [DATA_W-1:0] rx_byte
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  eng_state_t        state;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              start_c, stop_c, waiting;

  assign start_c = sda_fall & scl_s;
  assign stop_c  = sda_rise & scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sr <= '0; cnt <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      ev_addr <= 1'b0; ev_rx <= 1'b0; ev_tx <= 1'b0;
      rw_bit <= 1'b0; nack <= 1'b0; rx_byte <= '0; waiting <= 1'b0;
    end else begin
      ev_addr <= 1'b0; ev_rx <= 1'b0; ev_tx <= 1'b0;
      if (!en) begin
        state <= S_IDLE; cnt <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0; waiting <= 1'b0;
      end else if (start_c) begin
        state <= S_ADDR; cnt <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0; waiting <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0; waiting <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR: begin
            if (scl_rise) begin
              sr <= {sr[DATA_W-2:0], sda_s}; cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (sr[DATA_W-1:1] == own_addr) begin
                sda_oe <= 1'b1; rw_bit <= sr[0]; state <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            sda_oe <= 1'b0; scl_oe <= 1'b1; ev_addr <= 1'b1; state <= S_HOLD;
          end
          S_HOLD: begin
            if (tx_sel && host_wr) begin
              sr <= host_wdata; sda_oe <= ~host_wdata[DATA_W-1];
              scl_oe <= 1'b0; cnt <= '0; state <= S_TX;
            end else if (!tx_sel && host_rd) begin
              scl_oe <= 1'b0; cnt <= '0; state <= S_RX;
            end
          end
          S_RX: begin
            if (scl_rise) begin
              sr <= {sr[DATA_W-2:0], sda_s}; cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              rx_byte <= sr; sda_oe <= ~ack_off; state <= S_RACK;
            end
          end
          S_RACK: if (scl_fall) begin
            sda_oe <= 1'b0; scl_oe <= 1'b1; ev_rx <= 1'b1; state <= S_HOLD;
          end
          S_TX: if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0; state <= S_TACK;
            end else begin
              sr <= {sr[DATA_W-2:0], 1'b0}; sda_oe <= ~sr[DATA_W-2]; cnt <= cnt + 1'b1;
            end
          end
          S_TACK: begin
            if (scl_rise) nack <= sda_s;
            else if (scl_fall) begin
              ev_tx <= 1'b1;
              if (nack) begin
                state <= S_IDLE; waiting <= 1'b1;
              end else begin
                scl_oe <= 1'b1; state <= S_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: a START seen while enabled restarts address reception with both lines released
  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_c) |=> (state == S_ADDR && !sda_oe && !scl_oe))
    else $error("R10 start did not restart address reception");

  // R9: after a master NACK the slave neither stretches nor drives data
  a_r9_nack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && state == S_WAIT) |-> (!scl_oe && !sda_oe))
    else $error("R9 bus driven after NACK");

  // R3: an idle slave (mismatch or no transfer) leaves both lines alone
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!scl_oe && !sda_oe))
    else $error("R3 idle slave drives the bus");
endmodule

// File: rtl/i2c_slave_stretch.sv
`timescale 1ns/1ps
module i2c_slave_stretch
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [1:0] ln_q, ln_rise, ln_fall;
  logic [ADDR_W-1:0] own_q;
  logic [2:0] ctrl_q;
  logic irq_q, aas_q, srw_q, rxak_q;
  logic ev_addr, ev_rx, ev_tx, rw_bit, nack;
  logic [DATA_W-1:0] rx_byte;
  logic wr_ctrl, wr_own, wr_stat, wr_data, rd_data, ev_any;

  i2cs_sync #(.N(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw({sda_i, scl_i}),
    .q(ln_q), .rise(ln_rise), .fall(ln_fall));

  assign wr_own  = reg_wr && reg_sel == SEL_OWN;
  assign wr_ctrl = reg_wr && reg_sel == SEL_CTRL;
  assign wr_stat = reg_wr && reg_sel == SEL_STAT;
  assign wr_data = reg_wr && reg_sel == SEL_DATA;
  assign rd_data = reg_rd && reg_sel == SEL_DATA;
  assign ev_any  = ev_addr | ev_rx | ev_tx;

  i2cs_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[CTL_EN]), .own_addr(own_q),
    .tx_sel(ctrl_q[CTL_TX]), .ack_off(ctrl_q[CTL_NOACK]),
    .scl_s(ln_q[0]), .sda_s(ln_q[1]),
    .scl_rise(ln_rise[0]), .scl_fall(ln_fall[0]),
    .sda_rise(ln_rise[1]), .sda_fall(ln_fall[1]),
    .host_wr(wr_data), .host_rd(rd_data), .host_wdata(reg_wdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ev_addr(ev_addr), .ev_rx(ev_rx), .ev_tx(ev_tx),
    .rw_bit(rw_bit), .nack(nack), .rx_byte(rx_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0; ctrl_q <= '0; irq_q <= 1'b0;
      aas_q <= 1'b0; srw_q <= 1'b0; rxak_q <= 1'b0;
    end else begin
      if (wr_own) own_q <= reg_wdata[ADDR_W-1:0];
      if (wr_ctrl) begin
        ctrl_q <= reg_wdata[2:0];
        aas_q  <= 1'b0;
      end
      if (wr_stat && reg_wdata[0]) irq_q <= 1'b0;
      if (ev_addr) begin
        irq_q <= 1'b1; aas_q <= 1'b1; srw_q <= rw_bit;
      end
      if (ev_rx) begin
        irq_q <= 1'b1; aas_q <= 1'b0;
      end
      if (ev_tx) begin
        irq_q <= 1'b1; aas_q <= 1'b0; rxak_q <= nack;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_OWN:  reg_rdata[ADDR_W-1:0] = own_q;
      SEL_CTRL: reg_rdata[2:0] = ctrl_q;
      SEL_STAT: reg_rdata[3:0] = {rxak_q, srw_q, aas_q, irq_q};
      default:  reg_rdata = rx_byte;
    endcase
  end

  assign irq = irq_q;

  // R5: a stretch is only released by a host access
  a_r5_stretch_until_access: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !reg_wr && !reg_rd) |=> scl_oe)
    else $error("R5 stretch released without host access");

  // R4: control write clears the addressed flag unless a new match lands
  a_r4_ctrl_clears_aas: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !ev_addr) |=> !aas_q)
    else $error("R4 addressed flag survived control write");

  // R11: write-one-to-clear of the pending interrupt
  a_r11_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[0] && !ev_any) |=> !irq)
    else $error("R11 interrupt not cleared");
endmodule

// File: tb/i2c_slave_stretch_tb.sv
`timescale 1ns/1ps
module i2c_slave_stretch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HQ = 10;
  localparam logic [7:0] OWN = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic [1:0] reg_sel = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  wire scl_w = m_scl & ~scl_oe;
  wire sda_w = m_sda & ~sda_oe;

  int vec_n = 0, err_n = 0;
  bit done = 0;
  logic [7:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slave_stretch dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (act !== exp) begin
      err_n++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor side: compare a produced byte against the oldest expected one
  task automatic sb_pop(input string tag, input logic [7:0] act);
    if (sb_q.size() == 0) chk({tag, " (queue empty)"}, act, 32'hFFFF);
    else chk(tag, act, sb_q.pop_front());
  endtask

  task automatic hold(input int n); repeat (n) @(negedge clk); endtask

  task automatic hw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic hr(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic scl_up;
    m_scl = 1'b1;
    @(negedge clk);
    while (scl_w !== 1'b1) @(negedge clk);
  endtask

  task automatic m_out(input logic b);
    m_sda = b; hold(HQ); scl_up; hold(HQ); m_scl = 1'b0; hold(2);
  endtask

  task automatic m_in(output logic b);
    m_sda = 1'b1; hold(HQ); scl_up; hold(HQ/2); b = sda_w; hold(HQ/2);
    m_scl = 1'b0; hold(2);
  endtask

  task automatic m_start;
    m_sda = 1'b1; m_scl = 1'b1; hold(HQ); m_sda = 1'b0; hold(HQ); m_scl = 1'b0; hold(2);
  endtask

  task automatic m_rstart;
    m_sda = 1'b1; hold(HQ); scl_up; hold(HQ); m_sda = 1'b0; hold(HQ); m_scl = 1'b0; hold(2);
  endtask

  task automatic m_stop;
    m_sda = 1'b0; hold(HQ); scl_up; hold(HQ); m_sda = 1'b1; hold(HQ);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) m_out(d[i]);
    m_in(b);
    acked = !b;
    hold(HQ);
  endtask

  task automatic m_rbyte(input logic ackbit, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_in(b); d[i] = b; end
    m_out(ackbit);
    hold(HQ);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      err_n++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic ak;
    hold(4); rst_n = 1'b1; hold(4);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0); chk("R1 irq", irq, 0);
    hr(2'd2, rd); chk("R1 status", rd, 8'h00);

    hw(2'd0, OWN); hw(2'd1, 8'h01);

    // R3 mismatch
    m_start; m_wbyte(8'h66, ak);
    chk("R3 no ack", ak, 0); chk("R3 no irq", irq, 0); chk("R3 no stretch", scl_oe, 0);
    m_wbyte(8'h00, ak); chk("R3 data ignored", ak, 0);
    m_stop;

    // R2 match, write direction
    m_start; m_wbyte({OWN[6:0], 1'b0}, ak);
    chk("R2 ack", ak, 1); chk("R2 irq", irq, 1);
    hr(2'd2, rd); chk("R2 status aas srw=0", rd, 8'h03);
    chk("R5 stretch after address", scl_oe, 1);
    hw(2'd1, 8'h01); hr(2'd2, rd); chk("R4 ctrl write clears aas", rd, 8'h01);
    hw(2'd2, 8'h01); chk("R11 irq cleared", irq, 0);
    hw(2'd3, 8'h55); hold(2); chk("R5 wrong direction keeps stretch", scl_oe, 1);
    hr(2'd3, rd); hold(2); chk("R5 read releases", scl_oe, 0);

    // R6 receive with ack
    sb_q.push_back(8'hC3);
    m_wbyte(8'hC3, ak); chk("R6 byte acked", ak, 1); chk("R5 stretch after byte", scl_oe, 1);
    hr(2'd2, rd); chk("R4 data irq aas clear", rd, 8'h01);
    hw(2'd2, 8'h01); hw(2'd1, 8'h05);
    hr(2'd3, rd); sb_pop("R6 received byte", rd);

    // R7 ack disabled
    sb_q.push_back(8'h3C);
    m_wbyte(8'h3C, ak); chk("R7 nack when disabled", ak, 0); chk("R7 irq", irq, 1);
    hw(2'd1, 8'h01); hw(2'd2, 8'h01);
    hr(2'd3, rd); sb_pop("R7 byte stored", rd);

    // R10 repeated start, then R8 transmit
    m_rstart; m_wbyte({OWN[6:0], 1'b1}, ak);
    chk("R10 address after restart acked", ak, 1);
    hr(2'd2, rd); chk("R2 status srw=1", rd, 8'h07);
    hw(2'd1, 8'h03); hw(2'd2, 8'h01);
    sb_q.push_back(8'hA5); hw(2'd3, 8'hA5);
    m_rbyte(1'b0, rd); sb_pop("R8 transmitted byte", rd);
    hr(2'd2, rd); chk("R8 status rxak=0", rd, 8'h05);
    chk("R5 stretch after tx byte", scl_oe, 1);
    hw(2'd2, 8'h01);
    sb_q.push_back(8'h81); hw(2'd3, 8'h81);
    m_rbyte(1'b1, rd); sb_pop("R8 second byte", rd);

    // R9 master NACK
    hr(2'd2, rd); chk("R9 status rxak=1", rd, 8'h0D);
    chk("R9 no stretch", scl_oe, 0); chk("R9 sda released", sda_oe, 0);
    for (int k = 0; k < 3; k++) begin m_in(ak); chk("R9 bus ignored", ak, 1); end
    m_stop;

    // R10 abort mid-byte
    hw(2'd2, 8'h01);
    m_start; m_wbyte({OWN[6:0], 1'b0}, ak); chk("R2 ack again", ak, 1);
    hw(2'd1, 8'h01); hw(2'd2, 8'h01); hr(2'd3, rd);
    m_out(1'b1); m_out(1'b0); m_out(1'b1); m_out(1'b1);
    m_rstart; m_wbyte({OWN[6:0], 1'b0}, ak);
    chk("R10 mid-byte restart acked", ak, 1);
    hr(2'd2, rd); chk("R10 status after abort", rd & 8'h07, 8'h03);
    hw(2'd1, 8'h01); hw(2'd2, 8'h01); hr(2'd3, rd);
    m_stop;

    // R12 disabled
    hw(2'd1, 8'h00);
    m_start; m_wbyte({OWN[6:0], 1'b0}, ak);
    chk("R12 no ack when disabled", ak, 0); chk("R12 no irq", irq, 0);
    chk("R12 no stretch", scl_oe, 0);
    m_stop;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
    $finish;
  end
endmodule